// File: doc/BRIEF.md
# Glitch-Free Clock Source Switch

This block picks which of two oscillators, a fast one and a slow one, drives the system clock output. It can move the output from one to the other while the output is in use, and it never emits a runt high or low pulse. Software, or a neighbouring block, drives a level select input. The block notices when that level differs from the source that is active now, and it then runs a switch sequence from an always-running timebase clock.

If the target oscillator is reported as not running when the switch begins, the controller first waits a start-up interval of a set number of timebase cycles. If the target is already running, it skips that wait.

The handover has three steps. The old source is gated off on one of its own falling edges. The output then stays low until a rising edge of the new source, at which point the new source passes through. When the handover is done, the per-source status flags swap and the busy indication drops.

A select change that arrives while a switch is running is not lost. The controller acts on it once the current switch completes.

Top module: `glitchless_clk_switch`

## Requirements
- R1: After reset (default `RST_LF` = 0) the fast source is active. `hf_live`=1, `lf_live`=0, `busy`=0, and `clk_out` follows `clk_hf`.
- R2: When `sel_lf` (1 = slow source wanted) differs from the active source at a timebase edge, `busy` is 1 from the following cycle until the switch completes. The status flags hold their values while `busy` is high.
- R3: While `sel_lf` matches the active source, `busy` stays 0 and the flags are unchanged, whatever `run_hf` and `run_lf` do.
- R4: If the target's run input is 0 when the switch starts, the old source is released only after a wait of `DLY_CYC` timebase cycles, so `busy` lasts at least `DLY_CYC` cycles.
- R5: If the target's run input is 1, no start-up wait is inserted. With the bench clocks the switch completes in fewer than `DLY_CYC` cycles.
- R6: The old source is gated off only while it is low, and the output stays low until a rising edge of the new source. No high or low pulse on `clk_out` is shorter than the shorter half-period of the two sources.
- R7: The two source gates are never open at the same time.
- R8: `hf_live` and `lf_live` are always one-hot, and they change only in the cycle in which `busy` falls.
- R9: A change of `sel_lf` made during a switch is carried out after that switch completes.
- R10: After completion, `clk_out` follows the newly selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tb | input | 1 | Always-running timebase for the controller and start-up counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_hf | input | 1 | Fast candidate clock |
| clk_lf | input | 1 | Slow candidate clock |
| sel_lf | input | 1 | Requested source level: 1 = slow, 0 = fast |
| run_hf | input | 1 | Fast oscillator currently running |
| run_lf | input | 1 | Slow oscillator currently running |
| clk_out | output | 1 | Switched system clock |
| hf_live | output | 1 | Fast source is the active output source |
| lf_live | output | 1 | Slow source is the active output source |
| busy | output | 1 | Switch in progress |

## Verification
The hardest state to reach from the ports is a select change arriving in the middle of a switch, while both gates are closed or one is still being handed over. The bench reaches it by reversing `sel_lf` a few timebase cycles after starting a switch, and then follows the flags through the forced round trip. Runt pulses can only be seen on the output waveform. A monitor therefore times every high and low phase of `clk_out` across all switches. The two start-up cases are separated by setting the target's run input low or high and timing how long `busy` stays high.

// File: rtl/clksw_pkg.sv
`timescale 1ns/1ps
package clksw_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WARM,
        ST_DROP,
        ST_RAISE
    } sw_state_e;
endpackage

// File: rtl/clksw_sync.sv
`timescale 1ns/1ps
module clksw_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= {STAGES{RST_VAL}};
        else        sh_q <= sh_d;
    end

    assign q = sh_q[STAGES-1];
endmodule

// File: rtl/clksw_gate.sv
`timescale 1ns/1ps
module clksw_gate #(
    parameter int   SYNC_N = 2,
    parameter logic RST_ON = 1'b0
) (
    input  logic clk_src,
    input  logic rst_n,
    input  logic want,
    output logic en
);
    logic want_s;
    logic en_d;
    logic en_q;

    clksw_sync #(.STAGES(SYNC_N), .RST_VAL(RST_ON)) u_want_sync (
        .clk   (clk_src),
        .rst_n (rst_n),
        .d     (want),
        .q     (want_s)
    );

    always_comb begin
        en_d = want_s;
    end

    // gate changes only on the falling edge, while the source is low
    always_ff @(negedge clk_src or negedge rst_n) begin
        if (!rst_n) en_q <= RST_ON;
        else        en_q <= en_d;
    end

    assign en = en_q;
endmodule

// File: rtl/clksw_ctrl.sv
`timescale 1ns/1ps
module clksw_ctrl
    import clksw_pkg::*;
#(
    parameter int   DLY_CYC = 100,
    parameter logic RST_LF  = 1'b0
) (
    input  logic clk_tb,
    input  logic rst_n,
    input  logic sel_lf,
    input  logic run_hf,
    input  logic run_lf,
    input  logic ack_hf,
    input  logic ack_lf,
    output logic want_hf,
    output logic want_lf,
    output logic hf_live,
    output logic lf_live,
    output logic busy
);
    localparam int CNT_W = $clog2(DLY_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DLY_CYC - 1);

    typedef struct packed {
        sw_state_e        st;
        logic             cur;
        logic [CNT_W-1:0] cnt;
        logic             want_hf;
        logic             want_lf;
        logic             hf_live;
        logic             lf_live;
        logic             busy;
    } ctrl_t;

    ctrl_t q_q;
    ctrl_t q_d;

    logic tgt_run;
    logic old_ack;
    logic new_ack;

    always_comb begin
        tgt_run = sel_lf ? run_lf : run_hf;
        old_ack = q_q.cur ? ack_lf : ack_hf;
        new_ack = q_q.cur ? ack_hf : ack_lf;
        q_d = q_q;
        unique case (q_q.st)
            ST_IDLE: begin
                if (sel_lf != q_q.cur) begin
                    q_d.busy = 1'b1;
                    q_d.cnt  = '0;
                    q_d.st   = tgt_run ? ST_DROP : ST_WARM;
                end
            end
            ST_WARM: begin
                if (q_q.cnt == CNT_LAST) q_d.st  = ST_DROP;
                else                     q_d.cnt = q_q.cnt + 1'b1;
            end
            ST_DROP: begin
                if (q_q.cur) q_d.want_lf = 1'b0;
                else         q_d.want_hf = 1'b0;
                if (!old_ack) q_d.st = ST_RAISE;
            end
            ST_RAISE: begin
                if (q_q.cur) q_d.want_hf = 1'b1;
                else         q_d.want_lf = 1'b1;
                if (new_ack) begin
                    q_d.st      = ST_IDLE;
                    q_d.cur     = !q_q.cur;
                    q_d.hf_live = q_q.cur;
                    q_d.lf_live = !q_q.cur;
                    q_d.busy    = 1'b0;
                end
            end
            default: q_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_tb or negedge rst_n) begin
        if (!rst_n) begin
            q_q.st      <= ST_IDLE;
            q_q.cur     <= RST_LF;
            q_q.cnt     <= '0;
            q_q.want_hf <= !RST_LF;
            q_q.want_lf <= RST_LF;
            q_q.hf_live <= !RST_LF;
            q_q.lf_live <= RST_LF;
            q_q.busy    <= 1'b0;
        end else begin
            q_q <= q_d;
        end
    end

    assign want_hf = q_q.want_hf;
    assign want_lf = q_q.want_lf;
    assign hf_live = q_q.hf_live;
    assign lf_live = q_q.lf_live;
    assign busy    = q_q.busy;
endmodule

// File: rtl/glitchless_clk_switch.sv
`timescale 1ns/1ps
module glitchless_clk_switch #(
    parameter int   DLY_CYC = 100,
    parameter logic RST_LF  = 1'b0,
    parameter int   SYNC_N  = 2
) (
    input  logic clk_tb,
    input  logic rst_n,
    input  logic clk_hf,
    input  logic clk_lf,
    input  logic sel_lf,
    input  logic run_hf,
    input  logic run_lf,
    output logic clk_out,
    output logic hf_live,
    output logic lf_live,
    output logic busy
);
    localparam int   NSRC = 2;
    localparam logic [NSRC-1:0] RST_ON = {RST_LF, !RST_LF};

    logic [NSRC-1:0] src_clk;
    logic [NSRC-1:0] want;
    logic [NSRC-1:0] en;
    logic [NSRC-1:0] ack;
    logic            en_hf;
    logic            en_lf;

    assign src_clk = {clk_lf, clk_hf};

    clksw_ctrl #(.DLY_CYC(DLY_CYC), .RST_LF(RST_LF)) u_ctrl (
        .clk_tb  (clk_tb),
        .rst_n   (rst_n),
        .sel_lf  (sel_lf),
        .run_hf  (run_hf),
        .run_lf  (run_lf),
        .ack_hf  (ack[0]),
        .ack_lf  (ack[1]),
        .want_hf (want[0]),
        .want_lf (want[1]),
        .hf_live (hf_live),
        .lf_live (lf_live),
        .busy    (busy)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        clksw_gate #(.SYNC_N(SYNC_N), .RST_ON(RST_ON[i])) u_gate (
            .clk_src (src_clk[i]),
            .rst_n   (rst_n),
            .want    (want[i]),
            .en      (en[i])
        );
        clksw_sync #(.STAGES(SYNC_N), .RST_VAL(RST_ON[i])) u_ack (
            .clk   (clk_tb),
            .rst_n (rst_n),
            .d     (en[i]),
            .q     (ack[i])
        );
    end

    assign en_hf   = en[0];
    assign en_lf   = en[1];
    assign clk_out = |(src_clk & en);
endmodule

// File: rtl/clksw_chk.sv
`timescale 1ns/1ps
module clksw_chk (
    input logic clk_tb,
    input logic rst_n,
    input logic en_hf,
    input logic en_lf,
    input logic clk_out,
    input logic hf_live,
    input logic lf_live,
    input logic busy
);
    // R7
    gate_excl_chk: assert property (@(posedge clk_tb) disable iff (!rst_n)
        $countones({en_hf, en_lf}) <= 1);

    // R6
    gap_low_chk: assert property (@(posedge clk_tb) disable iff (!rst_n)
        (!en_hf && !en_lf) |-> !clk_out);

    // R8
    flag_onehot_chk: assert property (@(posedge clk_tb) disable iff (!rst_n)
        $onehot({hf_live, lf_live}));

    // R8
    flag_done_chk: assert property (@(posedge clk_tb) disable iff (!rst_n)
        ($rose(lf_live) || $fell(lf_live)) |-> $fell(busy));

    // R2
    flag_hold_chk: assert property (@(posedge clk_tb) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(hf_live));
endmodule

bind glitchless_clk_switch clksw_chk u_chk (
    .clk_tb  (clk_tb),
    .rst_n   (rst_n),
    .en_hf   (en_hf),
    .en_lf   (en_lf),
    .clk_out (clk_out),
    .hf_live (hf_live),
    .lf_live (lf_live),
    .busy    (busy)
);

// File: tb/sim_glitchless_clk_switch.sv
`timescale 1ns/1ps
module sim_glitchless_clk_switch;
    localparam int DLY = 300;

    logic clk_tb = 1'b0;
    logic clk_hf = 1'b0;
    logic clk_lf = 1'b0;
    logic rst_n = 1'b0;
    logic sel_lf = 1'b0;
    logic run_hf = 1'b1;
    logic run_lf = 1'b1;
    logic clk_out, hf_live, lf_live, busy;

    int n_chk = 0;
    int n_bad = 0;
    int glitch = 0;
    bit mon_on = 1'b0;
    realtime t_r = 0.0;
    realtime t_f = 0.0;

    always #4   clk_tb = ~clk_tb;
    always #20  clk_hf = ~clk_hf;
    always #100 clk_lf = ~clk_lf;

    glitchless_clk_switch #(.DLY_CYC(DLY)) u0 (
        .clk_tb (clk_tb), .rst_n (rst_n), .clk_hf (clk_hf), .clk_lf (clk_lf),
        .sel_lf (sel_lf), .run_hf (run_hf), .run_lf (run_lf),
        .clk_out (clk_out), .hf_live (hf_live), .lf_live (lf_live), .busy (busy)
    );

    // pulse-width monitor for R6
    always @(posedge clk_out) begin
        if (mon_on && t_f > 0.0 && ($realtime - t_f) < 19.0) glitch++;
        t_r = $realtime;
    end
    always @(negedge clk_out) begin
        if (mon_on && t_r > 0.0 && ($realtime - t_r) < 19.0) glitch++;
        t_f = $realtime;
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
        end
    endtask

    task automatic follow(input bit lf);
        for (int i = 0; i < 3; i++) begin
            if (lf) @(posedge clk_lf); else @(posedge clk_hf);
            #1;
            chk(clk_out == 1'b1, "R10 clk_out high", clk_out, 1);
            if (lf) @(negedge clk_lf); else @(negedge clk_hf);
            #1;
            chk(clk_out == 1'b0, "R10 clk_out low", clk_out, 0);
        end
    endtask

    task automatic do_switch(input bit to_lf, input bit tgt_run, output int cyc);
        @(negedge clk_tb);
        if (to_lf) run_lf = tgt_run; else run_hf = tgt_run;
        sel_lf = to_lf;
        @(negedge clk_tb);
        chk(busy == 1'b1, "R2 busy after request", busy, 1);
        cyc = 1;
        while (busy && cyc < 5000) begin
            @(negedge clk_tb);
            cyc++;
        end
        chk(busy == 1'b0, "R2 busy cleared", busy, 0);
        chk(lf_live == to_lf && hf_live == !to_lf, "R8 flags", {hf_live, lf_live},
            {!to_lf, to_lf});
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk_tb);
        rst_n = 1'b1;
        repeat (2) @(negedge clk_tb);
        mon_on = 1'b1;
        chk(hf_live == 1'b1, "R1 hf_live", hf_live, 1);
        chk(lf_live == 1'b0, "R1 lf_live", lf_live, 0);
        chk(busy == 1'b0, "R1 busy", busy, 0);
        follow(1'b0);
    endtask

    task automatic t_ignore();
        bit seen = 1'b0;
        @(negedge clk_tb);
        run_hf = 1'b0; run_lf = 1'b0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk_tb);
            if (i == 10) begin run_hf = 1'b1; run_lf = 1'b1; end
            if (busy || !hf_live || lf_live) seen = 1'b1;
        end
        chk(!seen, "R3 matching select ignored", seen, 0);
        follow(1'b0);
    endtask

    task automatic t_fast_switch();
        int cyc;
        do_switch(1'b1, 1'b1, cyc);
        chk(cyc < DLY, "R5 no start-up wait", cyc, DLY);
        follow(1'b1);
    endtask

    task automatic t_slow_start();
        int cyc;
        do_switch(1'b0, 1'b0, cyc);
        chk(cyc >= DLY, "R4 start-up wait applied", cyc, DLY);
        run_hf = 1'b1;
        follow(1'b0);
    endtask

    task automatic t_pending();
        int  n = 0;
        bit  saw_lf = 1'b0;
        @(negedge clk_tb);
        sel_lf = 1'b1;
        repeat (6) @(negedge clk_tb);
        chk(busy == 1'b1, "R9 busy mid-switch", busy, 1);
        sel_lf = 1'b0;
        while (!lf_live && n < 5000) begin @(negedge clk_tb); n++; end
        saw_lf = lf_live;
        chk(saw_lf, "R9 first switch completed", saw_lf, 1);
        n = 0;
        while (!(hf_live && !busy) && n < 5000) begin @(negedge clk_tb); n++; end
        chk(hf_live == 1'b1, "R9 returned to fast", hf_live, 1);
        chk(busy == 1'b0, "R9 idle at end", busy, 0);
        follow(1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk_tb);
        n_bad++;
        $display("FAIL watchdog R2 act=timeout exp=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_ignore();
        t_fast_switch();
        t_slow_start();
        t_pending();
        chk(glitch == 0, "R6 no runt pulses", glitch, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule